// File: doc/BRIEF.md
# Energy Sign-Change Interrupt Unit

This unit watches three energy-to-pulse channels. Each channel feeds signed power samples into a first-stage accumulator. Whenever the running sum reaches the positive or the negative threshold, one threshold quantum is removed and the sign of that quantum is taken as the current sign of the channel's energy flow. When this sign differs from the sign last seen on the channel, a sign change is noted. It is then held pending until the next high-to-low transition of that channel's pulse output.

On that falling edge the unit raises the channel's status flag and loads the pending sign into the channel's sign bit. Software can therefore tie each event to a specific output pulse. A mask word selects which flags drive an active-low interrupt line. Software clears a flag by writing a 1 to its position in the status word. The power computation and the pulse generator sit outside the block. The pulse outputs reach it as plain inputs.

Top module: `esc_sign_irq`

## Requirements
- R1: After reset the status word and the sign word are all zero (every channel reads positive) and `irq_n` is high.
- R2: On each valid sample, a channel adds the sample to its accumulator. If the sum is at or above +THR, THR is subtracted and a positive crossing occurs. If the sum is at or below -THR, THR is added and a negative crossing occurs. Otherwise the sum is kept as it is.
- R3: A crossing whose sign equals the channel's last seen sign (positive after reset) never sets a status flag.
- R4: A sign change stays pending with no visible effect until the channel's pulse input falls. If the sign flips and flips back before that edge, the flag is still set and the sign bit keeps its value.
- R5: The status flag and the sign bit update on the clock edge that first samples the pulse input low after it was sampled high. They are visible in the cycle after `cf_in` goes low. Sign bit 0 means positive and 1 means negative.
- R6: Channels 0, 1 and 2 have status flags at bits 9, 13 and 18 of `status_word` and sign bits at bits 3, 7 and 8 of `sign_word`. All other bits read 0.
- R7: `irq_n` is low exactly while some status flag is set and the mask bit at the same position is set. The mask is written with `wr_addr`=1 and `wr_en`=1.
- R8: A write with `wr_addr`=0 clears each status flag whose bit is 1 in `wr_data`. Zero bits, and writes to the mask address, leave the flags unchanged.
- R9: If a clearing write and a set event hit the same flag on the same clock, the flag ends up set.
- R10: A rising edge or a steady high level on a pulse input changes no flag and no sign bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 3 | Per-channel sample strobe |
| smp_data | input | 3*PW | Per-channel signed samples, channel c at bits [c*PW +: PW] |
| cf_in | input | 3 | Per-channel pulse output from the pulse generator |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = status word (write one to clear), 1 = mask word |
| wr_data | input | 32 | Write data |
| status_word | output | 32 | Status flags |
| sign_word | output | 32 | Committed sign bits |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The hardest states to reach are those where a set event and a clear meet on one clock, and where a sign flips twice while a pulse is pending. Both depend on accumulator contents that are not visible at the ports. The bench keeps its own arithmetic model of every accumulator. It feeds a channel a large sample of the needed sign until the model shows a pending change, and only then drives the pulse edge. In the collision case it drives the falling edge and the clearing write in the same cycle.

// File: rtl/esc_pkg.sv
package esc_pkg;
    localparam int NCH    = 3;
    localparam int WORD_W = 32;
    localparam logic ADDR_STATUS = 1'b0;
    localparam logic ADDR_MASK   = 1'b1;

    typedef struct packed {
        logic hit;
        logic neg;
    } cross_t;

    typedef struct packed {
        logic flag;
        logic neg;
    } chan_view_t;

    function automatic int stat_pos(input int ch);
        case (ch)
            0:       return 9;
            1:       return 13;
            default: return 18;
        endcase
    endfunction

    function automatic int sign_pos(input int ch);
        case (ch)
            0:       return 3;
            1:       return 7;
            default: return 8;
        endcase
    endfunction
endpackage

// File: rtl/esc_accum.sv
module esc_accum
    import esc_pkg::*;
#(
    parameter int PW  = 16,
    parameter int AW  = 24,
    parameter int THR = 4096
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 vld,
    input  logic signed [PW-1:0] smp,
    output cross_t               cross_o
);
    localparam logic signed [AW-1:0] LIM  = AW'(THR);
    localparam logic signed [AW-1:0] NLIM = -LIM;

    logic signed [AW-1:0] acc;
    logic signed [AW-1:0] sum_c;

    always_comb begin
        sum_c = acc + signed'({{(AW-PW){smp[PW-1]}}, smp});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc     <= '0;
            cross_o <= '0;
        end else begin
            cross_o.hit <= 1'b0;
            if (vld) begin
                if (sum_c >= LIM) begin
                    acc     <= sum_c - LIM;
                    cross_o <= '{hit: 1'b1, neg: 1'b0};
                end else if (sum_c <= NLIM) begin
                    acc     <= sum_c + LIM;
                    cross_o <= '{hit: 1'b1, neg: 1'b1};
                end else begin
                    acc <= sum_c;
                end
            end
        end
    end
endmodule

// File: rtl/esc_track.sv
module esc_track
    import esc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  cross_t     cross_i,
    input  logic       cf_i,
    input  logic       clr_i,
    output chan_view_t view_o
);
    logic last_neg;
    logic pend;
    logic pend_neg;
    logic cf_q;
    logic fall_c;
    logic commit_c;
    logic change_c;

    always_comb begin
        fall_c   = cf_q & ~cf_i;
        commit_c = fall_c & pend;
        change_c = cross_i.hit && (cross_i.neg != last_neg);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_neg <= 1'b0;
            pend     <= 1'b0;
            pend_neg <= 1'b0;
            cf_q     <= 1'b0;
            view_o   <= '0;
        end else begin
            cf_q <= cf_i;
            if (change_c) begin
                last_neg <= cross_i.neg;
                pend     <= 1'b1;
                pend_neg <= cross_i.neg;
            end else if (commit_c) begin
                pend <= 1'b0;
            end
            if (commit_c) begin
                view_o.flag <= 1'b1;
                view_o.neg  <= pend_neg;
            end else if (clr_i) begin
                view_o.flag <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/esc_regs.sv
module esc_regs
    import esc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [NCH-1:0]    flags,
    output logic [NCH-1:0]    clr,
    output logic              irq_n
);
    logic [NCH-1:0] mask_q;

    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            clr[i] = wr_en && (wr_addr == ADDR_STATUS) && wr_data[stat_pos(i)];
        end
        irq_n = ~|(flags & mask_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (wr_en && (wr_addr == ADDR_MASK)) begin
            for (int i = 0; i < NCH; i++) begin
                mask_q[i] <= wr_data[stat_pos(i)];
            end
        end
    end
endmodule

// File: rtl/esc_sign_irq.sv
module esc_sign_irq
    import esc_pkg::*;
#(
    parameter int PW  = 16,
    parameter int AW  = 24,
    parameter int THR = 4096
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NCH-1:0]        smp_vld,
    input  logic [NCH*PW-1:0]     smp_data,
    input  logic [NCH-1:0]        cf_in,
    input  logic                  wr_en,
    input  logic                  wr_addr,
    input  logic [WORD_W-1:0]     wr_data,
    output logic [WORD_W-1:0]     status_word,
    output logic [WORD_W-1:0]     sign_word,
    output logic                  irq_n
);
    cross_t         cross_w [NCH];
    chan_view_t     view_w  [NCH];
    logic [NCH-1:0] flags_w;
    logic [NCH-1:0] clr_w;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        esc_accum #(.PW(PW), .AW(AW), .THR(THR)) u_acc (
            .clk     (clk),
            .rst     (rst),
            .vld     (smp_vld[c]),
            .smp     (signed'(smp_data[c*PW +: PW])),
            .cross_o (cross_w[c])
        );
        esc_track u_trk (
            .clk     (clk),
            .rst     (rst),
            .cross_i (cross_w[c]),
            .cf_i    (cf_in[c]),
            .clr_i   (clr_w[c]),
            .view_o  (view_w[c])
        );
        assign flags_w[c] = view_w[c].flag;
    end

    esc_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .flags   (flags_w),
        .clr     (clr_w),
        .irq_n   (irq_n)
    );

    always_comb begin
        status_word = '0;
        sign_word   = '0;
        for (int i = 0; i < NCH; i++) begin
            status_word[stat_pos(i)] = view_w[i].flag;
            sign_word[sign_pos(i)]   = view_w[i].neg;
        end
    end
endmodule

// File: rtl/esc_sign_irq_chk.sv
module esc_sign_irq_chk
    import esc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [NCH-1:0]    cf_in,
    input logic              wr_en,
    input logic              wr_addr,
    input logic [WORD_W-1:0] wr_data,
    input logic [WORD_W-1:0] status_word,
    input logic [WORD_W-1:0] sign_word,
    input logic              irq_n
);
    // R7
    irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
        !irq_n |-> (status_word != '0));

    // R7
    irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (status_word == '0) |-> irq_n);

    for (genvar c = 0; c < NCH; c++) begin : g_c
        localparam int SP = stat_pos(c);
        localparam int GP = sign_pos(c);

        // R5
        flag_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(status_word[SP]) |-> ($past(cf_in[c], 2) && !$past(cf_in[c])));

        // R5
        sign_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
            !$stable(sign_word[GP]) |-> ($past(cf_in[c], 2) && !$past(cf_in[c])));

        // R8
        clear_by_write_chk: assert property (@(posedge clk) disable iff (rst)
            $fell(status_word[SP]) |->
                $past(wr_en && (wr_addr == ADDR_STATUS) && wr_data[SP]));
    end
endmodule

bind esc_sign_irq esc_sign_irq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cf_in       (cf_in),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .status_word (status_word),
    .sign_word   (sign_word),
    .irq_n       (irq_n)
);

// File: tb/tb_esc_sign_irq.sv
module tb_esc_sign_irq;
    localparam int PW  = 16;
    localparam int AW  = 24;
    localparam int THR = 100;
    localparam int NC  = 3;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NC-1:0]   smp_vld = '0;
    logic [NC*PW-1:0] smp_data = '0;
    logic [NC-1:0]   cf_in = '0;
    logic            wr_en = 1'b0;
    logic            wr_addr = 1'b0;
    logic [31:0]     wr_data = '0;
    logic [31:0]     status_word;
    logic [31:0]     sign_word;
    logic            irq_n;

    int checks = 0;
    int errors = 0;

    int m_acc [NC];
    int m_last[NC];
    int m_pend[NC];
    int m_pneg[NC];
    int m_flag[NC];
    int m_neg [NC];
    int m_mask[NC];

    esc_sign_irq #(.PW(PW), .AW(AW), .THR(THR)) dut (
        .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_data(smp_data),
        .cf_in(cf_in), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .status_word(status_word), .sign_word(sign_word), .irq_n(irq_n)
    );

    always #5 clk = ~clk;

    function automatic int spos(input int ch);
        return (ch == 0) ? 9 : (ch == 1) ? 13 : 18;
    endfunction

    function automatic int gpos(input int ch);
        return (ch == 0) ? 3 : (ch == 1) ? 7 : 8;
    endfunction

    task automatic check_all(input string tag);
        logic [31:0] es, eg;
        logic ei;
        es = '0; eg = '0; ei = 1'b1;
        for (int i = 0; i < NC; i++) begin
            es[spos(i)] = (m_flag[i] != 0);
            eg[gpos(i)] = (m_neg[i] != 0);
            if (m_flag[i] != 0 && m_mask[i] != 0) ei = 1'b0;
        end
        checks++;
        if (status_word !== es) begin
            errors++;
            $display("FAIL %s status_word actual %h expected %h", tag, status_word, es);
        end
        checks++;
        if (sign_word !== eg) begin
            errors++;
            $display("FAIL %s sign_word actual %h expected %h", tag, sign_word, eg);
        end
        checks++;
        if (irq_n !== ei) begin
            errors++;
            $display("FAIL %s irq_n actual %b expected %b", tag, irq_n, ei);
        end
    endtask

    // R2 model: stage-one accumulation and crossing sign
    task automatic put(input int ch, input int v);
        int s;
        logic [31:0] vv;
        vv = v;
        smp_vld[ch] = 1'b1;
        smp_data[ch*PW +: PW] = vv[PW-1:0];
        @(negedge clk);
        smp_vld[ch] = 1'b0;
        s = m_acc[ch] + v;
        if (s >= THR) begin
            m_acc[ch] = s - THR;
            if (m_last[ch] != 0) begin m_last[ch] = 0; m_pend[ch] = 1; m_pneg[ch] = 0; end
        end else if (s <= -THR) begin
            m_acc[ch] = s + THR;
            if (m_last[ch] != 1) begin m_last[ch] = 1; m_pend[ch] = 1; m_pneg[ch] = 1; end
        end else begin
            m_acc[ch] = s;
        end
    endtask

    task automatic pulse(input int ch, input bit clr);
        cf_in[ch] = 1'b1;
        @(negedge clk);
        check_all("R10");
        @(negedge clk);
        check_all("R10");
        cf_in[ch] = 1'b0;
        if (clr) begin
            wr_en = 1'b1; wr_addr = 1'b0; wr_data = '0; wr_data[spos(ch)] = 1'b1;
        end
        check_all("R4");
        @(negedge clk);
        wr_en = 1'b0;
        if (m_pend[ch] != 0) begin
            m_flag[ch] = 1; m_neg[ch] = m_pneg[ch]; m_pend[ch] = 0;
        end else if (clr) begin
            m_flag[ch] = 0;
        end
        check_all(clr ? "R9" : "R5");
    endtask

    task automatic wr(input logic a, input logic [31:0] d, input string tag);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        for (int i = 0; i < NC; i++) begin
            if (a == 1'b0) begin
                if (d[spos(i)]) m_flag[i] = 0;
            end else begin
                m_mask[i] = d[spos(i)];
            end
        end
        check_all(tag);
    endtask

    task automatic flip(input int ch);
        while (m_pend[ch] == 0) put(ch, (m_last[ch] != 0) ? 150 : -150);
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] mw;
        for (int i = 0; i < NC; i++) begin
            m_acc[i] = 0; m_last[i] = 0; m_pend[i] = 0; m_pneg[i] = 0;
            m_flag[i] = 0; m_neg[i] = 0; m_mask[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_all("R1");

        // R3: positive crossings match the reset sign, no flag
        put(1, 60); put(1, 60); put(1, 90);
        pulse(1, 1'b0);
        check_all("R3");

        // R2 R5 R6 sweep over sample patterns on every channel
        for (int ch = 0; ch < NC; ch++) begin
            for (int k = 0; k < 40; k++) begin
                put(ch, ((k * 53 + ch * 17) % 301) - 150);
                if (k % 4 == 3) pulse(ch, 1'b0);
            end
            check_all("R2");
            check_all("R6");
        end

        // make sure every channel carries a flag
        for (int ch = 0; ch < NC; ch++) begin
            flip(ch);
            pulse(ch, 1'b0);
        end

        // R7 mask sweep
        for (int m = 0; m < 8; m++) begin
            mw = '0;
            for (int i = 0; i < NC; i++) mw[spos(i)] = m[i];
            wr(1'b1, mw, "R7");
        end

        // R8 clear behaviour
        wr(1'b0, 32'h0, "R8");
        wr(1'b1, 32'hFFFF_FFFF, "R8");
        mw = '0; mw[13] = 1'b1;
        wr(1'b0, mw, "R8");
        wr(1'b0, 32'hFFFF_FFFF, "R8");

        // R9 set and clear on the same clock
        flip(0); pulse(0, 1'b0);
        flip(0);
        pulse(0, 1'b1);
        mw = '0; mw[9] = 1'b1;
        wr(1'b0, mw, "R8");

        // R4 double flip before the edge
        flip(2);
        while (m_last[2] != m_neg[2] || m_pend[2] == 0) put(2, (m_last[2] != 0) ? 150 : -150);
        @(negedge clk);
        check_all("R4");
        pulse(2, 1'b0);
        check_all("R4");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule